// File: doc/BRIEF.md
# Daisy-Chain Command Frame Builder

This block builds command frames for a daisy-chained battery-monitor link. The host offers one request at a time: a write type, a device identifier, a 16-bit register address, up to eight data bytes and a byte count. The block assembles the frame and streams it out one byte per handshake on a byte-wide valid/ready port. A frame is a header byte, an optional device-ID byte, one or two address bytes, the payload, and a 16-bit CRC trailer.

A second mode builds a read request. The host gives the number of bytes it wants back, and the block emits a single-device read frame whose one payload byte is that number minus one. Requests with an illegal length are refused. A refused request produces no bytes and a one-cycle reject pulse.

The CRC is computed one bit per clock, eight clocks per covered byte. Each covered byte is presented only after its CRC update is done, and the two trailer bytes follow back to back.

Top module: `chain_frame_tx`

## Requirements
- R1: `reqKind` selects the write type. 0 is a single-device read with response (code 0x80), 1 is a single-device write without response (0x90), 2 is a broadcast read with response (0xC0) and 3 is a broadcast write without response (0xD0).
- R2: The first frame byte is the type code ORed with the data count, then ORed with 0x88 if the address is above 255 and with 0x80 otherwise.
- R3: An address above 255 is sent as two bytes, high byte first. Any other address is sent as one byte holding its low eight bits.
- R4: The device-ID byte comes right after the header for types 0x80 and 0x90 only. Broadcast frames leave it out.
- R5: In write mode, a count of 7 or above 8 is refused. No byte is emitted, `busy` stays low, and `reject` is high for exactly the cycle after the accepting edge.
- R6: The CRC starts at zero and covers every byte from the header through the last payload byte. It is the reflected CRC-16 with polynomial 0xA001, applied least significant bit first.
- R7: The CRC is sent low byte first, then high byte, so a frame is two bytes longer than its header-to-payload part.
- R8: With `reqRead` high, the frame is type 0x80 with count 1, and its payload byte is `reqCount` minus 1. A `reqCount` of 0 or above 128 is refused as in R5.
- R9: Payload bytes come from `reqData`, most significant used byte first. With count n, the first payload byte is bits [8n-1:8n-8].
- R10: A request is taken only while `reqReady` is high, which is only while idle. `busy` is high from the accepting edge until the edge that hands off the high CRC byte.
- R11: While `outValid` is high and `outReady` is low, `outValid` and `outByte` hold their values.
- R12: A synchronous active-high `rst`, even in the middle of a frame, returns the block to idle with `outValid`, `busy` and `reject` low and `reqReady` high.
- R13: The header becomes valid on the eighth rising edge after the accepting edge. Each later header-to-payload byte becomes valid on the eighth edge after the previous handoff. The low CRC byte becomes valid on the edge that hands off the last payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request will be taken |
| reqRead | input | 1 | Build a read-request frame instead of a write frame |
| reqKind | input | 2 | Write type select (R1) |
| reqDevId | input | 8 | Target device identifier |
| reqAddr | input | 16 | Register address |
| reqData | input | 64 | Payload word, used bytes right-aligned |
| reqCount | input | 8 | Data byte count, or the return byte count in read mode |
| outValid | output | 1 | `outByte` holds a frame byte |
| outReady | input | 1 | Sink takes the byte on this edge |
| outByte | output | 8 | Frame byte |
| busy | output | 1 | Frame in progress |
| reject | output | 1 | One-cycle pulse for a refused request |

## Verification
A refused request shows `reject` at the first sample after the edge that sees it. An accepted request shows `busy` at that same sample. The first header byte then appears exactly eight samples later, and the bench counts those samples and compares the count with eight. Later bytes are not tied to fixed cycles. A monitor compares each byte against a queue of expected values at the sample just before the handoff edge, so random backpressure stretches the frame without changing what is compared. While the output is stalled, the bench also requires the same byte at every sample until it is taken.

// File: rtl/frame_pkg.sv
package frame_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;      // capture a new request
    logic crcShift;  // fold one bit of the current byte into the CRC
  } strobe_t;

  localparam logic [15:0] CrcPoly = 16'hA001;

  // Type code for a 2-bit kind: bit 4 selects write, bit 6 selects broadcast.
  function automatic logic [7:0] typeCode(input logic [1:0] kind);
    return {1'b1, kind[1], 1'b0, kind[0], 4'h0};
  endfunction

endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_pkg::*;
#(
  parameter int IdxW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reqValid,
  input  logic            reqBad,
  input  logic            outReady,
  input  logic [IdxW-1:0] bodyLen,
  output strobe_t         strobe,
  output logic            reqReady,
  output logic            outValid,
  output logic            busy,
  output logic            reject,
  output logic [IdxW-1:0] idx,
  output logic [2:0]      bitCnt
);

  typedef enum logic [1:0] {StIdle, StCrc, StSend} state_t;
  state_t state;

  logic [IdxW-1:0] nextIdx;
  logic [IdxW-1:0] trailEnd;
  logic            handoff;

  assign nextIdx  = idx + 1'b1;
  assign trailEnd = bodyLen + IdxW'(2);
  assign handoff  = (state == StSend) && outReady;

  always_comb begin
    strobe          = '0;
    strobe.load     = (state == StIdle) && reqValid && !reqBad;
    strobe.crcShift = (state == StCrc);
  end

  assign reqReady = (state == StIdle);
  assign outValid = (state == StSend);
  assign busy     = (state != StIdle);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= StIdle;
      idx    <= '0;
      bitCnt <= '0;
      reject <= 1'b0;
    end else begin
      reject <= (state == StIdle) && reqValid && reqBad;
      case (state)
        StIdle: begin
          if (reqValid && !reqBad) begin
            state  <= StCrc;
            idx    <= '0;
            bitCnt <= '0;
          end
        end
        StCrc: begin
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) state <= StSend;
        end
        StSend: begin
          if (outReady) begin
            idx <= nextIdx;
            if (nextIdx < bodyLen) begin
              state  <= StCrc;
              bitCnt <= '0;
            end else if (nextIdx < trailEnd) begin
              state <= StSend;
            end else begin
              state <= StIdle;
            end
          end
        end
        default: state <= StIdle;
      endcase
    end
  end

  // R5: a refused request never starts a frame
  p_reject_idle_r5: assert property (@(posedge clk) disable iff (rst)
    reject |-> !busy);

  // R13: the low CRC byte follows the last body byte without a gap
  p_trailer_gapless_r13: assert property (@(posedge clk) disable iff (rst)
    (handoff && nextIdx == bodyLen) |=> outValid);

  // R10: busy only falls on a handoff of the final byte
  p_busy_end_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !handoff) |=> busy);

endmodule

// File: rtl/frame_dp.sv
module frame_dp
  import frame_pkg::*;
#(
  parameter int MaxData = 8,
  parameter int IdxW    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  strobe_t              strobe,
  input  logic [IdxW-1:0]      idx,
  input  logic [2:0]           bitCnt,
  input  logic                 reqRead,
  input  logic [1:0]           reqKind,
  input  logic [7:0]           reqDevId,
  input  logic [15:0]          reqAddr,
  input  logic [MaxData*8-1:0] reqData,
  input  logic [7:0]           reqCount,
  output logic                 reqBad,
  output logic [IdxW-1:0]      bodyLen,
  output logic [7:0]           outByte
);

  localparam int DataW   = MaxData * 8;
  localparam int MaxBody = 4 + MaxData;
  localparam int SlotN   = 1 << IdxW;

  logic [7:0]       effType;
  logic [7:0]       effCnt;
  logic             idOn;
  logic             wide;
  logic [DataW-1:0] payload;
  logic [7:0]       newBytes [SlotN];
  logic [IdxW-1:0]  newLen;
  logic [7:0]       frameBytes [SlotN];
  logic [15:0]      crc;
  logic [15:0]      crcNext;
  logic             fb;

  // Length rules for both modes.
  always_comb begin
    if (reqRead) reqBad = (reqCount == 8'd0) || (reqCount > 8'd128);
    else         reqBad = (reqCount == 8'd7) || (reqCount > 8'(MaxData));
  end

  assign effType = reqRead ? 8'h80 : typeCode(reqKind);
  assign effCnt  = reqRead ? 8'd1 : reqCount;
  assign idOn    = !effType[6];
  assign wide    = (reqAddr > 16'd255);
  assign payload = reqRead ? DataW'(reqCount - 8'd1) : reqData;

  // Lay the header-to-payload bytes out in slots.
  always_comb begin
    logic [IdxW-1:0]  slot;
    logic [DataW-1:0] sh;
    for (int k = 0; k < SlotN; k++) newBytes[k] = 8'h00;
    newBytes[0] = effType | effCnt | (wide ? 8'h88 : 8'h80);
    slot = IdxW'(1);
    if (idOn) begin
      newBytes[slot] = reqDevId;
      slot = slot + 1'b1;
    end
    if (wide) begin
      newBytes[slot] = reqAddr[15:8];
      slot = slot + 1'b1;
    end
    newBytes[slot] = reqAddr[7:0];
    slot = slot + 1'b1;
    for (int i = 0; i < MaxData; i++) begin
      sh = '0;
      if (i < int'(effCnt)) begin
        sh = payload >> (8 * (int'(effCnt) - 1 - i));
        newBytes[slot + IdxW'(i)] = sh[7:0];
      end
    end
    newLen = slot + effCnt[IdxW-1:0];
  end

  // One bit of the reflected CRC per strobe.
  assign fb      = crc[0] ^ frameBytes[idx][bitCnt];
  assign crcNext = (crc >> 1) ^ (fb ? CrcPoly : 16'h0000);

  always_ff @(posedge clk) begin
    if (rst) begin
      crc     <= '0;
      bodyLen <= '0;
      for (int k = 0; k < SlotN; k++) frameBytes[k] <= 8'h00;
    end else if (strobe.load) begin
      crc     <= '0;
      bodyLen <= newLen;
      for (int k = 0; k < SlotN; k++) frameBytes[k] <= newBytes[k];
    end else if (strobe.crcShift) begin
      crc <= crcNext;
    end
  end

  always_comb begin
    if (idx < bodyLen)       outByte = frameBytes[idx];
    else if (idx == bodyLen) outByte = crc[7:0];
    else                     outByte = crc[15:8];
  end

  // R12: reset leaves the CRC register clear
  p_crc_clear_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (crc == 16'h0000));

  // R2: a captured frame has between two header-to-payload bytes and the maximum
  p_body_len_r2: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.load) |-> (bodyLen >= IdxW'(2) && bodyLen <= IdxW'(MaxBody)));

endmodule

// File: rtl/chain_frame_tx.sv
module chain_frame_tx
  import frame_pkg::*;
#(
  parameter int MaxData = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqRead,
  input  logic [1:0]           reqKind,
  input  logic [7:0]           reqDevId,
  input  logic [15:0]          reqAddr,
  input  logic [MaxData*8-1:0] reqData,
  input  logic [7:0]           reqCount,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [7:0]           outByte,
  output logic                 busy,
  output logic                 reject
);

  localparam int MaxFrame = 4 + MaxData + 2;
  localparam int IdxW     = $clog2(MaxFrame + 1);

  strobe_t         strobe;
  logic            reqBad;
  logic [IdxW-1:0] bodyLen;
  logic [IdxW-1:0] idx;
  logic [2:0]      bitCnt;

  frame_ctrl #(.IdxW(IdxW)) ctrl_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqBad(reqBad),
    .outReady(outReady), .bodyLen(bodyLen), .strobe(strobe),
    .reqReady(reqReady), .outValid(outValid), .busy(busy),
    .reject(reject), .idx(idx), .bitCnt(bitCnt)
  );

  frame_dp #(.MaxData(MaxData), .IdxW(IdxW)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .idx(idx), .bitCnt(bitCnt),
    .reqRead(reqRead), .reqKind(reqKind), .reqDevId(reqDevId),
    .reqAddr(reqAddr), .reqData(reqData), .reqCount(reqCount),
    .reqBad(reqBad), .bodyLen(bodyLen), .outByte(outByte)
  );

  // R11: a stalled byte stays put
  p_hold_byte_r11: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outByte)));

endmodule

// File: tb/chain_frame_tx_tb_top.sv
module chain_frame_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqRead = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [7:0]  reqDevId = 8'h00;
  logic [15:0] reqAddr = 16'h0000;
  logic [63:0] reqData = 64'h0;
  logic [7:0]  reqCount = 8'd0;
  logic        outValid;
  logic        outReady;
  logic [7:0]  outByte;
  logic        busy;
  logic        reject;

  always #5 clk = ~clk;

  chain_frame_tx dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqRead(reqRead), .reqKind(reqKind), .reqDevId(reqDevId),
    .reqAddr(reqAddr), .reqData(reqData), .reqCount(reqCount),
    .outValid(outValid), .outReady(outReady), .outByte(outByte),
    .busy(busy), .reject(reject)
  );

  int errs = 0;
  int checks = 0;
  logic [7:0] expQ [$];
  string      tagQ [$];
  bit         stall = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Independent model of the frame.
  task automatic buildExp(input bit rd, input logic [1:0] kind, input logic [7:0] id,
                          input logic [15:0] addr, input logic [63:0] data,
                          input logic [7:0] cnt);
    logic [7:0]  body [$];
    string       btag [$];
    logic [7:0]  typ;
    logic [7:0]  n;
    logic [15:0] crc;
    bit          wide;
    case (kind)
      2'd0: typ = 8'h80;
      2'd1: typ = 8'h90;
      2'd2: typ = 8'hC0;
      default: typ = 8'hD0;
    endcase
    if (rd) typ = 8'h80;
    n = rd ? 8'd1 : cnt;
    wide = (addr > 16'd255);
    body.push_back(typ | n | (wide ? 8'h88 : 8'h80)); btag.push_back("R1 R2 header");
    if (typ == 8'h80 || typ == 8'h90) begin body.push_back(id); btag.push_back("R4 id"); end
    if (wide) begin body.push_back(addr[15:8]); btag.push_back("R3 addr-hi"); end
    body.push_back(addr[7:0]); btag.push_back("R3 addr-lo");
    if (rd) begin
      body.push_back(cnt - 8'd1); btag.push_back("R8 return-count");
    end else begin
      for (int i = int'(n) - 1; i >= 0; i--) begin
        body.push_back(data[i*8 +: 8]); btag.push_back("R9 payload");
      end
    end
    crc = 16'h0000;
    foreach (body[j]) begin
      crc = crc ^ {8'h00, body[j]};
      for (int b = 0; b < 8; b++) crc = crc[0] ? ((crc >> 1) ^ 16'hA001) : (crc >> 1);
      expQ.push_back(body[j]); tagQ.push_back(btag[j]);
    end
    expQ.push_back(crc[7:0]);  tagQ.push_back("R6 R7 crc-lo");
    expQ.push_back(crc[15:8]); tagQ.push_back("R6 R7 crc-hi");
  endtask

  task automatic offer(input bit rd, input logic [1:0] kind, input logic [7:0] id,
                       input logic [15:0] addr, input logic [63:0] data,
                       input logic [7:0] cnt, input bit bad);
    int lat;
    @(negedge clk);
    reqRead = rd; reqKind = kind; reqDevId = id; reqAddr = addr;
    reqData = data; reqCount = cnt; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    if (bad) begin
      @(negedge clk);
      reqValid = 1'b0;
      chk(reject === 1'b1 && busy === 1'b0, rd ? "R8" : "R5", "refusal pulse",
          {reject, busy}, 2'b10);
      @(negedge clk);
      chk(reject === 1'b0, rd ? "R8" : "R5", "pulse width", reject, 0);
    end else begin
      chk(expQ.size() == 0, "R10", "accepted before previous frame ended", expQ.size(), 0);
      buildExp(rd, kind, id, addr, data, cnt);
      @(negedge clk);
      reqValid = 1'b0;
      chk(busy === 1'b1 && reqReady === 1'b0, "R10", "busy after accept",
          {busy, reqReady}, 2'b10);
      lat = 0;
      while (!outValid) begin @(negedge clk); lat++; end
      chk(lat == 8, "R13", "header latency", lat, 8);
    end
  endtask

  // Sink backpressure, changed away from the edge.
  initial begin
    outReady = 1'b1;
    forever begin
      @(posedge clk);
      #2;
      outReady = stall ? lfsr[0] : 1'b1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
  end

  // Monitor / scoreboard.
  bit         holdOn = 1'b0;
  logic [7:0] holdByte;
  initial begin
    forever begin
      @(negedge clk);
      if (rst) holdOn = 1'b0;
      else if (outValid) begin
        if (holdOn) chk(outByte == holdByte, "R11", "stalled byte changed", outByte, holdByte);
        if (!outReady) begin
          holdOn = 1'b1; holdByte = outByte;
        end else begin
          holdOn = 1'b0;
          if (expQ.size() == 0) chk(1'b0, "R5", "unexpected byte", outByte, 0);
          else begin
            logic [7:0] e;
            string t;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            chk(outByte == e, t, "frame byte", outByte, e);
          end
        end
      end else holdOn = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(outValid === 1'b0 && busy === 1'b0 && reqReady === 1'b1 && reject === 1'b0,
        "R12", "reset state", {outValid, busy, reqReady, reject}, 4'b0010);
    rst = 1'b0;

    offer(0, 2'd1, 8'h00, 16'h0020, 64'h3C, 8'd1, 0);           // single write, short addr
    offer(0, 2'd3, 8'h07, 16'h0105, 64'h3C3C, 8'd2, 0);         // broadcast write, long addr
    offer(0, 2'd0, 8'h05, 16'h0215, 64'hDEADBEEF, 8'd4, 0);     // single read
    offer(0, 2'd2, 8'h01, 16'h00FF, 64'h0, 8'd0, 0);            // broadcast read, 255 boundary
    offer(0, 2'd1, 8'h0A, 16'h0100, 64'h0123456789ABCDEF, 8'd8, 0); // 256 boundary, full
    offer(0, 2'd3, 8'h00, 16'h0029, 64'h112233445566, 8'd6, 0);
    offer(0, 2'd1, 8'h3E, 16'hFFFF, 64'hA1B2C3D4E5, 8'd5, 0);
    offer(0, 2'd1, 8'h01, 16'h0010, 64'h1234, 8'd7, 1);         // R5 count 7
    offer(0, 2'd3, 8'h01, 16'h0010, 64'h1234, 8'd9, 1);         // R5 count 9
    offer(1, 2'd3, 8'h02, 16'h0215, 64'h0, 8'd1, 0);            // R8 byte 0
    offer(1, 2'd3, 8'h02, 16'h0010, 64'h0, 8'd128, 0);          // R8 byte 127
    offer(1, 2'd0, 8'h02, 16'h0010, 64'h0, 8'd129, 1);          // R8 over limit
    offer(1, 2'd0, 8'h02, 16'h0010, 64'h0, 8'd0, 1);            // R8 zero

    stall = 1'b1;                                               // R11 under backpressure
    offer(0, 2'd1, 8'h0C, 16'h0300, 64'hFEDCBA9876543210, 8'd8, 0);
    offer(0, 2'd2, 8'h00, 16'h0007, 64'h55AA, 8'd2, 0);
    offer(1, 2'd1, 8'h09, 16'h0105, 64'h0, 8'd12, 0);
    stall = 1'b0;

    // R12: reset in the middle of a frame
    offer(0, 2'd0, 8'h04, 16'h0400, 64'h77665544, 8'd4, 0);
    repeat (12) @(negedge clk);
    rst = 1'b1;
    expQ.delete(); tagQ.delete();
    @(negedge clk);
    rst = 1'b0;
    chk(outValid === 1'b0 && busy === 1'b0 && reqReady === 1'b1 && reject === 1'b0,
        "R12", "mid-frame reset", {outValid, busy, reqReady, reject}, 4'b0010);
    offer(0, 2'd1, 8'h02, 16'h0022, 64'h00, 8'd1, 0);

    while (expQ.size() != 0 || busy) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(expQ.size() == 0 && outValid === 1'b0, "R10", "idle at end", expQ.size(), 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule